// File: doc/BRIEF.md
# System control register file

This block holds the privileged 32-bit control registers that a processor core reaches through its coprocessor move instructions. Every request carries a 4-bit primary register number, a 4-bit secondary selector, two 3-bit opcode fields, a privilege flag and a read/write strobe. On the same cycle the block says whether the request is accepted or rejected. An accepted read returns data. An accepted write is filtered through a per-register keep mask and a force-to-one mask, and the new value is stored on the next rising clock edge.

Storage is split into a main bank and an alternate bank, each with sixteen entries. The secondary opcode picks the bank: zero selects the main bank and any other value selects the alternate bank. Four further breakpoint registers sit behind main register 14 and are chosen by the secondary selector. Bit 13 of main entry 15 is driven out continuously so that neighbouring coprocessors can use it as their access enable.

The block has no state machine. Its response logic is combinational from the request, and the only sequential logic is the register storage.

Top module: `sysctl_regfile`

## Requirements
- R1: A request is rejected when `req_priv` is 0 or when `req_op1` is nonzero.
- R2: Registers 0 and 1 are legal with any `req_op2` provided `req_crm`=0. Registers 2, 3, 5, 6 and 13 need `req_crm`=0 and `req_op2`=0. Registers 4, 11 and 12 are never legal.
- R3: Register 7 is legal only for these (op2, CRm) pairs: (0,5), (0,6), (0,7), (1,5), (1,6), (1,10), (4,10), (5,2), (6,5).
- R4: Register 8 is legal for op2 0 with CRm 5 to 7, and for op2 1 with CRm 5 or 6. Registers 9 and 10 need op2=0 and CRm 0 or 1. Register 14 needs op2=0 and CRm in {0,3,4,8,9}. Register 15 needs op2=0 and CRm=1.
- R5: While `req_valid` is 1, exactly one of `rsp_accept` and `rsp_reject` is 1 in that same cycle. While `req_valid` is 0, both are 0.
- R6: A rejected request changes no stored value, and `rsp_rdata` is zero while it is presented. `rsp_rdata` is also zero for writes and for idle cycles.
- R7: After reset, main entry 0 reads 0x69052000, alternate entry 0 reads 0x0B1AA1AA, main entry 1 reads 0x00000078, and every other entry, including the breakpoint registers, reads 0.
- R8: With nonzero op2 the alternate bank is addressed. Its entry 0 is read-only. A write to its entry 1 stores data AND 0x33. Writes to any other alternate entry are dropped, and those entries read 0.
- R9: Main entry 0 is read-only. A write to main entry 1 stores (data AND 0x3B87) OR 0x78.
- R10: Main-bank writes are masked per entry: entry 2 keeps 0xFFFFC000, entry 5 keeps 0x6FF, entry 9 keeps 0x1, entry 13 keeps 0xFE000000, entry 15 keeps 0x3FFF, and entries 3 and 6 keep all bits. Writes to entries 7, 8 and 10 are ignored, and those entries read 0.
- R11: On register 14 with op2=0, CRm 3, 4, 8 and 9 each select their own breakpoint register for both read and write. CRm 0 selects main entry 14.
- R12: `cop_enable` equals bit 13 of main entry 15 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = core is in a privileged mode |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary selector |
| req_op1 | input | 3 | First opcode field, must be zero |
| req_op2 | input | 3 | Second opcode field, selects the bank |
| req_wdata | input | 32 | Write data |
| rsp_accept | output | 1 | Request is legal, same cycle |
| rsp_reject | output | 1 | Request is illegal, same cycle |
| rsp_rdata | output | 32 | Read data for an accepted read, otherwise 0 |
| cop_enable | output | 1 | Bit 13 of main entry 15 |

## Verification
The accept, reject and read-data responses are combinational, so each one is due in the cycle its request is driven. The bench drives every request just after a falling edge and compares all outputs two nanoseconds later, which is before the next rising edge. A write takes effect on the rising edge that closes its request cycle, so the reference model applies the write only after that cycle's comparison, and the read that follows on the next cycle must see the new value. `cop_enable` is compared in every request cycle against the model state from before that cycle's write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DW      = 32;
    localparam int NREG    = 16;
    localparam int NDBG    = 4;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int DIDX_W  = $clog2(NDBG);
    localparam int EN_BIT  = 13;

    localparam logic [DW-1:0] MAIN_ID_RST = 32'h6905_2000;
    localparam logic [DW-1:0] ALT_ID_RST  = 32'h0B1A_A1AA;
    localparam logic [DW-1:0] CTRL_FORCE  = 32'h0000_0078;
    localparam logic [DW-1:0] ALT1_KEEP   = 32'h0000_0033;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_MAIN,
        TGT_ALT,
        TGT_DBG
    } wr_tgt_e;

    // Bits of a main-bank entry that a write may change; zero means the write is dropped.
    function automatic logic [DW-1:0] main_keep(input logic [RIDX_W-1:0] idx);
        case (idx)
            4'd1:    return 32'h0000_3B87;
            4'd2:    return 32'hFFFF_C000;
            4'd3:    return 32'hFFFF_FFFF;
            4'd5:    return 32'h0000_06FF;
            4'd6:    return 32'hFFFF_FFFF;
            4'd9:    return 32'h0000_0001;
            4'd13:   return 32'hFE00_0000;
            4'd14:   return 32'hFFFF_FFFF;
            4'd15:   return 32'h0000_3FFF;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] main_force(input logic [RIDX_W-1:0] idx);
        return (idx == 4'd1) ? CTRL_FORCE : '0;
    endfunction

    function automatic logic [DW-1:0] main_rst(input logic [RIDX_W-1:0] idx);
        case (idx)
            4'd0:    return MAIN_ID_RST;
            4'd1:    return CTRL_FORCE;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_access_chk.sv
module sysctl_access_chk
    import sysctl_pkg::*;
(
    input  logic              priv,
    input  logic [RIDX_W-1:0] crn,
    input  logic [3:0]        crm,
    input  logic [2:0]        op1,
    input  logic [2:0]        op2,
    output logic              legal
);
    logic pair_ok;

    always_comb begin
        pair_ok = 1'b0;
        unique case (crn)
            4'd0, 4'd1: pair_ok = (crm == 4'd0);
            4'd2, 4'd3, 4'd5, 4'd6, 4'd13:
                pair_ok = (crm == 4'd0) && (op2 == 3'd0);
            4'd7: begin
                unique case (op2)
                    3'd0:    pair_ok = crm inside {4'd5, 4'd6, 4'd7};
                    3'd1:    pair_ok = crm inside {4'd5, 4'd6, 4'd10};
                    3'd4:    pair_ok = (crm == 4'd10);
                    3'd5:    pair_ok = (crm == 4'd2);
                    3'd6:    pair_ok = (crm == 4'd5);
                    default: pair_ok = 1'b0;
                endcase
            end
            4'd8: pair_ok = ((op2 == 3'd0) && (crm inside {4'd5, 4'd6, 4'd7}))
                         || ((op2 == 3'd1) && (crm inside {4'd5, 4'd6}));
            4'd9, 4'd10: pair_ok = (op2 == 3'd0) && (crm inside {4'd0, 4'd1});
            4'd14: pair_ok = (op2 == 3'd0) && (crm inside {4'd0, 4'd3, 4'd4, 4'd8, 4'd9});
            4'd15: pair_ok = (op2 == 3'd0) && (crm == 4'd1);
            default: pair_ok = 1'b0;
        endcase
        legal = priv && (op1 == 3'd0) && pair_ok;
    end
endmodule

// File: rtl/sysctl_wmask.sv
module sysctl_wmask
    import sysctl_pkg::*;
(
    input  logic [RIDX_W-1:0] crn,
    input  logic [3:0]        crm,
    input  logic [2:0]        op2,
    input  logic [DW-1:0]     wdata,
    output wr_tgt_e           tgt,
    output logic [DIDX_W-1:0] dbg_sel,
    output logic              dbg_hit,
    output logic [DW-1:0]     wval
);
    always_comb begin
        dbg_hit = (op2 == 3'd0) && (crn == 4'd14) && (crm != 4'd0);
        case (crm)
            4'd4:    dbg_sel = 2'd1;
            4'd8:    dbg_sel = 2'd2;
            4'd9:    dbg_sel = 2'd3;
            default: dbg_sel = 2'd0;
        endcase
    end

    always_comb begin
        tgt  = TGT_NONE;
        wval = '0;
        if (op2 != 3'd0) begin
            if (crn == 4'd1) begin
                tgt  = TGT_ALT;
                wval = wdata & ALT1_KEEP;
            end
        end else if (dbg_hit) begin
            tgt  = TGT_DBG;
            wval = wdata;
        end else if (main_keep(crn) != '0) begin
            tgt  = TGT_MAIN;
            wval = (wdata & main_keep(crn)) | main_force(crn);
        end
    end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [RIDX_W-1:0] req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op1,
    input  logic [2:0]        req_op2,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_accept,
    output logic              rsp_reject,
    output logic [DW-1:0]     rsp_rdata,
    output logic              cop_enable
);
    logic [NREG-1:0][DW-1:0] main_q;
    logic [NREG-1:0][DW-1:0] alt_q;
    logic [NDBG-1:0][DW-1:0] dbg_q;

    logic              legal;
    wr_tgt_e           tgt;
    logic [DIDX_W-1:0] dbg_sel;
    logic              dbg_hit;
    logic [DW-1:0]     wval;
    logic [DW-1:0]     rd_sel;
    logic              wr_en;

    sysctl_access_chk u_chk (
        .priv  (req_priv),
        .crn   (req_crn),
        .crm   (req_crm),
        .op1   (req_op1),
        .op2   (req_op2),
        .legal (legal)
    );

    sysctl_wmask u_wmask (
        .crn     (req_crn),
        .crm     (req_crm),
        .op2     (req_op2),
        .wdata   (req_wdata),
        .tgt     (tgt),
        .dbg_sel (dbg_sel),
        .dbg_hit (dbg_hit),
        .wval    (wval)
    );

    assign rsp_accept = req_valid && legal;
    assign rsp_reject = req_valid && !legal;
    assign wr_en      = rsp_accept && req_write;
    assign cop_enable = main_q[15][EN_BIT];

    always_comb begin
        if (req_op2 != 3'd0)
            rd_sel = alt_q[req_crn];
        else if (dbg_hit)
            rd_sel = dbg_q[dbg_sel];
        else
            rd_sel = main_q[req_crn];
        rsp_rdata = (rsp_accept && !req_write) ? rd_sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                main_q[i] <= main_rst(RIDX_W'(i));
                alt_q[i]  <= (i == 0) ? ALT_ID_RST : '0;
            end
            dbg_q <= '0;
        end else if (wr_en) begin
            case (tgt)
                TGT_MAIN: main_q[req_crn] <= wval;
                TGT_ALT:  alt_q[req_crn]  <= wval;
                TGT_DBG:  dbg_q[dbg_sel]  <= wval;
                default:  ;
            endcase
        end
    end

    // R1: unprivileged or nonzero opcode_1 requests are refused
    p_user_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!req_priv || req_op1 != 3'd0)) |-> rsp_reject);

    // R5: one response per request, none when idle
    p_one_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot({rsp_accept, rsp_reject}));
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(rsp_accept || rsp_reject));

    // R6: refused requests return zero and leave storage unchanged
    p_reject_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> (rsp_rdata == '0));
    p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && rsp_reject)
        |=> ($stable(main_q) && $stable(alt_q) && $stable(dbg_q)));

    // R9: the forced-one field of the control entry never clears
    p_ctrl_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (main_q[1] & CTRL_FORCE) == CTRL_FORCE);

    // R9: the identity entry survives every write
    p_id_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        main_q[0] == MAIN_ID_RST);
endmodule

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
    logic [3:0]  req_crn = '0, req_crm = '0;
    logic [2:0]  req_op1 = '0, req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_accept, rsp_reject, cop_enable;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [31:0] m_main [16];
    bit [31:0] m_alt  [16];
    bit [31:0] m_dbg  [int];

    always #5 clk = ~clk;

    sysctl_regfile u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_crn(req_crn), .req_crm(req_crm), .req_op1(req_op1),
        .req_op2(req_op2), .req_wdata(req_wdata), .rsp_accept(rsp_accept),
        .rsp_reject(rsp_reject), .rsp_rdata(rsp_rdata), .cop_enable(cop_enable)
    );

    function automatic bit m_legal(bit p, int n, int m, int o1, int o2);
        int key = o2 * 16 + m;
        if (!p || o1 != 0) return 0;
        if (n == 4 || n == 11 || n == 12) return 0;
        if (n <= 1) return m == 0;
        if (n == 7) return key inside {5, 6, 7, 21, 22, 26, 74, 82, 101};
        if (n == 8) return (o2 <= 1) && (m >= 5) && (m <= 7) && !(o2 == 1 && m == 7);
        if (o2 != 0) return 0;
        if (n == 9 || n == 10) return m <= 1;
        if (n == 14) return m inside {0, 3, 4, 8, 9};
        if (n == 15) return m == 1;
        return m == 0;
    endfunction

    function automatic bit [31:0] m_read(int n, int m, int o2);
        if (o2 != 0) return m_alt[n];
        if (n == 14 && m != 0) return m_dbg[m];
        return m_main[n];
    endfunction

    function automatic void m_write(int n, int m, int o2, bit [31:0] d);
        if (o2 != 0) begin
            if (n == 1) m_alt[1] = d & 32'h33;
            return;
        end
        case (n)
            1:  m_main[1] = (d & 32'h3B87) | 32'h78;
            2:  m_main[2] = d & 32'hFFFFC000;
            3:  m_main[3] = d;
            5:  m_main[5] = d & 32'h6FF;
            6:  m_main[6] = d;
            9:  m_main[9] = d & 32'h1;
            13: m_main[13] = d & 32'hFE000000;
            14: if (m == 0) m_main[14] = d; else m_dbg[m] = d;
            15: m_main[15] = d & 32'h3FFF;
            default: ;
        endcase
    endfunction

    function automatic void m_reset();
        foreach (m_main[i]) begin m_main[i] = 0; m_alt[i] = 0; end
        m_main[0] = 32'h69052000;
        m_main[1] = 32'h78;
        m_alt[0]  = 32'h0B1AA1AA;
        m_dbg[3] = 0; m_dbg[4] = 0; m_dbg[8] = 0; m_dbg[9] = 0;
    endfunction

    function automatic string leg_tag(bit p, int n, int o1);
        if (!p || o1 != 0) return "R1";
        if (n == 7) return "R3";
        if (n inside {8, 9, 10, 14, 15}) return "R4";
        return "R2";
    endfunction

    function automatic string dat_tag(int n, int o2);
        if (o2 != 0) return "R8";
        if (n <= 1) return "R9";
        if (n == 14) return "R11";
        return "R10";
    endfunction

    task automatic chk(string tag, string what, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(bit w, bit p, int n, int m, int o1, int o2, bit [31:0] d, string ovr);
        bit lg;
        bit [31:0] exp_rd;
        string dt;
        @(negedge clk);
        req_valid = 1; req_write = w; req_priv = p;
        req_crn = 4'(n); req_crm = 4'(m); req_op1 = 3'(o1); req_op2 = 3'(o2); req_wdata = d;
        #2;
        lg = m_legal(p, n, m, o1, o2);
        exp_rd = (lg && !w) ? m_read(n, m, o2) : 32'h0;
        dt = (ovr != "") ? ovr : (!lg ? "R6" : dat_tag(n, o2));
        chk(leg_tag(p, n, o1), "accept", 32'(rsp_accept), 32'(lg));
        chk("R5", "reject", 32'(rsp_reject), 32'(!lg));
        chk(dt, "rdata", rsp_rdata, exp_rd);
        chk("R12", "cop_enable", 32'(cop_enable), 32'(m_main[15][13]));
        if (lg && w) m_write(n, m, o2, d);
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_valid = 0; req_write = 0;
        #2;
        chk("R5", "idle accept", 32'(rsp_accept), 0);
        chk("R5", "idle reject", 32'(rsp_reject), 0);
        chk("R6", "idle rdata", rsp_rdata, 0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        chk("R7", "reset accept", 32'(rsp_accept), 0);
        chk("R12", "reset cop_enable", 32'(cop_enable), 0);
        rst_n = 1;

        // R7: reset contents, visible through legal reads
        access(0, 1, 0, 0, 0, 0, 0, "R7");
        access(0, 1, 0, 0, 0, 3, 0, "R7");
        access(0, 1, 1, 0, 0, 0, 0, "R7");
        for (int c = 0; c < 16; c++) access(0, 1, 14, c, 0, 0, 0, "R7");
        idle_check();

        // R2 R3 R4: full legality sweep with reads
        for (int n = 0; n < 16; n++)
            for (int m = 0; m < 16; m++)
                for (int o = 0; o < 8; o++)
                    access(0, 1, n, m, 0, o, 0, "");

        // R1: user mode and nonzero opcode_1
        for (int n = 0; n < 16; n++) begin
            access(0, 0, n, (n == 15) ? 1 : 0, 0, 0, 0, "");
            for (int o1 = 1; o1 < 8; o1++) access(0, 1, n, (n == 15) ? 1 : 0, o1, 0, 0, "");
        end
        access(1, 0, 1, 0, 0, 0, 32'h0, "");
        access(0, 1, 1, 0, 0, 0, 0, "R1");
        access(1, 1, 3, 0, 4, 0, 32'hDEAD_BEEF, "");
        access(0, 1, 3, 0, 0, 0, 0, "R1");

        // R8 R9 R10 R11 R6: every write combination, read back next cycle
        for (int pat = 0; pat < 3; pat++)
            for (int n = 0; n < 16; n++)
                for (int m = 0; m < 16; m++)
                    for (int o = 0; o < 8; o++) begin
                        bit [31:0] d;
                        d = (pat == 0) ? 32'hFFFF_FFFF : (pat == 1) ? 32'h0 : $urandom;
                        access(1, 1, n, m, 0, o, d, "");
                        access(0, 1, n, m, 0, o, 0, m_legal(1, n, m, 0, o) ? "" : "R6");
                    end

        // R11: distinct breakpoint values, R12: enable bit toggling
        access(1, 1, 14, 3, 0, 0, 32'h1111_0003, "");
        access(1, 1, 14, 4, 0, 0, 32'h2222_0004, "");
        access(1, 1, 14, 8, 0, 0, 32'h3333_0008, "");
        access(1, 1, 14, 9, 0, 0, 32'h4444_0009, "");
        access(1, 1, 14, 0, 0, 0, 32'h5555_0000, "");
        foreach (m_dbg[k]) access(0, 1, 14, k, 0, 0, 0, "R11");
        access(0, 1, 14, 0, 0, 0, 0, "R11");
        access(1, 1, 15, 1, 0, 0, 32'h0000_2000, "");
        access(0, 1, 15, 1, 0, 0, 0, "R12");
        access(1, 1, 15, 1, 0, 0, 32'hFFFF_DFFF, "");
        access(0, 1, 15, 1, 0, 0, 0, "R10");
        idle_check();

        done = 1;
        summary();
        $finish;
    end
endmodule